// File: doc/BRIEF.md
# HDR-DDR Write Word Generator

This block turns a single high-data-rate double-data-rate write request into a series of 20-bit words. Each word is aligned to the least significant bit, so it can be pushed into a transmit queue one word per handshake. A request starts with a command code and a 7-bit target dynamic address on a command handshake. The 16-bit payloads follow on a separate data stream with valid, ready and a last flag.

The block emits three kinds of word, in order. First comes one command word. Then come the data words; the first of these carries a different preamble from the ones after it. Last comes a closing word that holds a fixed token and a 5-bit CRC, accumulated over every payload of the message. The block fills in the two parity bits of each command and data word. It passes the data stream through without buffering, so output back-pressure stalls the data input directly.

Top module: `hdr_ddr_wr_gen`

## Requirements
- R1: Right after reset, `cmd_ready` is 1, while `out_valid` and `dat_ready` are both 0.
- R2: The command word has these fields. Bits [19:18] are 2'b01. Bit 17 is 0, so code bit 7 is ignored. Bits [16:10] are code bits [6:0]. Bits [9:3] are the address. Bit 2 is 0. Bits [1:0] are the parity of bits [17:2].
- R3: The first data word of a message has 2'b10 in [19:18], the payload in [17:2] and parity in [1:0].
- R4: Every data word after the first has 2'b11 in [19:18], the payload in [17:2] and parity in [1:0].
- R5: For a word whose 16-bit payload P sits in bits [17:2], parity bit 1 is the XOR of the odd bits of P. Parity bit 0 is the inverted XOR of the even bits of P.
- R6: The closing word has 2'b01 in [19:18], 4'hC in [17:14], the CRC5 in [13:9] and zeros in [8:0]. Once it is accepted, the block is idle again.
- R7: The CRC5 uses polynomial x^5+x^2+1 and starts at 5'h1F for each message. It shifts in the command payload (word bits [17:2]) and then each data payload, most significant bit first.
- R8: While `out_valid` is 1 and `out_ready` is 0, the output word holds its value. `dat_ready` is never 1 while `out_ready` is 0.
- R9: If the first data word is flagged last, the closing word comes directly after it.
- R10: `cmd_ready` stays 0 from command acceptance until the closing word is accepted. The command word is presented in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Write request present |
| cmd_ready | output | 1 | Block idle, request taken |
| cmd_code | input | 8 | Write command code |
| cmd_addr | input | 7 | Target dynamic address |
| dat_valid | input | 1 | Payload present |
| dat_ready | output | 1 | Payload taken |
| dat_word | input | 16 | Payload |
| dat_last | input | 1 | Payload is the message's final one |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes output word |
| out_word | output | 20 | Generated word |

## Verification
The bench uses several kinds of message. Single-payload messages separate the first-word path from the later-word path and show that the closing word follows at once. Long random messages with gaps on the data input and random back-pressure show that preambles change only after the first payload and that the CRC accumulates across all payloads. All-zero and all-one payloads, plus a code with bit 7 set, expose parity inversion and code masking. A forced stall in the middle of a message shows that the output holds its value and that the input is blocked.

// File: rtl/hdw_pkg.sv
package hdw_pkg;
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_CMD   = 3'd1,
      PH_FIRST = 3'd2,
      PH_NEXT  = 3'd3,
      PH_CRC   = 3'd4
   } phase_t;

   localparam logic [1:0] PRE_CTRL  = 2'b01;
   localparam logic [1:0] PRE_FIRST = 2'b10;
   localparam logic [1:0] PRE_NEXT  = 2'b11;
endpackage

// File: rtl/hdw_parity.sv
module hdw_parity #(
   parameter int DATA_W   = 16,
   parameter bit EVEN_INV = 1'b1
) (
   input  logic [DATA_W-1:0] payload,
   output logic [1:0]        parity
);
   localparam int HALF_W = DATA_W / 2;

   logic [HALF_W-1:0] odd_bits;
   logic [HALF_W-1:0] even_bits;

   for (genvar i = 0; i < HALF_W; i++) begin : g_split
      assign odd_bits[i]  = payload[2*i+1];
      assign even_bits[i] = payload[2*i];
   end

   if (EVEN_INV) begin : g_inv
      assign parity = {^odd_bits, ~(^even_bits)};
   end else begin : g_plain
      assign parity = {^odd_bits, ^even_bits};
   end
endmodule

// File: rtl/hdw_crc.sv
module hdw_crc #(
   parameter int          DATA_W = 16,
   parameter int          CRC_W  = 5,
   parameter logic [CRC_W-1:0] POLY = 5'h05,
   parameter logic [CRC_W-1:0] INIT = 5'h1F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              upd,
   input  logic [DATA_W-1:0] din,
   output logic [CRC_W-1:0]  crc
);
   logic [CRC_W-1:0] crc_nxt;

   always_comb begin
      logic fb;
      crc_nxt = crc;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         fb      = crc_nxt[CRC_W-1] ^ din[i];
         crc_nxt = {crc_nxt[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    crc <= INIT;
      else if (init) crc <= INIT;
      else if (upd)  crc <= crc_nxt;
   end
endmodule

// File: rtl/hdw_seq.sv
module hdw_seq
   import hdw_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   cmd_valid,
   output logic   cmd_ready,
   input  logic   dat_valid,
   input  logic   dat_last,
   output logic   dat_ready,
   output logic   out_valid,
   input  logic   out_ready,
   output phase_t phase,
   output logic   crc_init,
   output logic   crc_upd
);
   phase_t phase_nxt;
   logic   in_data;
   logic   fire;

   assign in_data   = (phase == PH_FIRST) || (phase == PH_NEXT);
   assign cmd_ready = (phase == PH_IDLE);
   assign out_valid = (phase == PH_CMD) || (phase == PH_CRC) || (in_data && dat_valid);
   assign dat_ready = in_data && out_ready;
   assign fire      = out_valid && out_ready;
   assign crc_init  = cmd_valid && cmd_ready;
   assign crc_upd   = fire && (phase != PH_CRC);

   always_comb begin
      phase_nxt = phase;
      case (phase)
         PH_IDLE:  if (cmd_valid) phase_nxt = PH_CMD;
         PH_CMD:   if (fire)      phase_nxt = PH_FIRST;
         PH_FIRST,
         PH_NEXT:  if (fire)      phase_nxt = dat_last ? PH_CRC : PH_NEXT;
         PH_CRC:   if (fire)      phase_nxt = PH_IDLE;
         default:                 phase_nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) phase <= PH_IDLE;
      else        phase <= phase_nxt;
   end

   // R8
   in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dat_ready |-> out_ready);
endmodule

// File: rtl/hdr_ddr_wr_gen.sv
module hdr_ddr_wr_gen
   import hdw_pkg::*;
#(
   parameter int          CODE_W   = 8,
   parameter int          ADDR_W   = 7,
   parameter int          DATA_W   = 16,
   parameter int          WORD_W   = 20,
   parameter int          CRC_W    = 5,
   parameter logic [3:0]  TOKEN    = 4'hC,
   parameter logic [CRC_W-1:0] CRC_POLY = 5'h05,
   parameter logic [CRC_W-1:0] CRC_INIT = 5'h1F,
   parameter bit          EVEN_INV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [CODE_W-1:0] cmd_code,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              dat_valid,
   output logic              dat_ready,
   input  logic [DATA_W-1:0] dat_word,
   input  logic              dat_last,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_word
);
   localparam int PAD_W = WORD_W - 2 - 4 - CRC_W;

   if (WORD_W != DATA_W + 4) begin : g_bad_word
      $error("WORD_W must equal DATA_W + 4");
   end
   if (CODE_W + ADDR_W + 1 != DATA_W) begin : g_bad_cmd
      $error("command fields must fill the payload");
   end
   if (PAD_W < 0) begin : g_bad_pad
      $error("closing word too narrow");
   end

   phase_t            phase;
   logic              crc_init, crc_upd;
   logic [CRC_W-1:0]  crc;
   logic [CODE_W-2:0] code_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] payload;
   logic [1:0]        parity;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q <= '0;
         addr_q <= '0;
      end else if (cmd_valid && cmd_ready) begin
         code_q <= cmd_code[CODE_W-2:0];
         addr_q <= cmd_addr;
      end
   end

   hdw_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_ready (cmd_ready),
      .dat_valid (dat_valid),
      .dat_last  (dat_last),
      .dat_ready (dat_ready),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .phase     (phase),
      .crc_init  (crc_init),
      .crc_upd   (crc_upd)
   );

   assign payload = (phase == PH_CMD) ? {1'b0, code_q, addr_q, 1'b0} : dat_word;

   hdw_parity #(.DATA_W(DATA_W), .EVEN_INV(EVEN_INV)) u_par (
      .payload (payload),
      .parity  (parity)
   );

   hdw_crc #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (crc_init),
      .upd   (crc_upd),
      .din   (payload),
      .crc   (crc)
   );

   always_comb begin
      case (phase)
         PH_CMD:   out_word = {PRE_CTRL,  payload, parity};
         PH_FIRST: out_word = {PRE_FIRST, payload, parity};
         PH_NEXT:  out_word = {PRE_NEXT,  payload, parity};
         PH_CRC:   out_word = {PRE_CTRL,  TOKEN, crc, {PAD_W{1'b0}}};
         default:  out_word = '0;
      endcase
   end

   // R8
   hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_word));

   // R10
   busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !cmd_ready);

   // R10
   cmd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready |=> out_valid && out_word[WORD_W-1 -: 2] == PRE_CTRL);

   // R6
   back_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_CRC && out_ready |=> cmd_ready && !out_valid);

   // R2
   preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_word[WORD_W-1 -: 2] != 2'b00);
endmodule

// File: tb/hdr_ddr_wr_gen_tb.sv
module hdr_ddr_wr_gen_tb;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n;
   logic        cmd_valid, cmd_ready;
   logic [7:0]  cmd_code;
   logic [6:0]  cmd_addr;
   logic        dat_valid, dat_ready, dat_last;
   logic [15:0] dat_word;
   logic        out_valid, out_ready;
   logic [19:0] out_word;

   hdr_ddr_wr_gen u_dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_code(cmd_code), .cmd_addr(cmd_addr),
      .dat_valid(dat_valid), .dat_ready(dat_ready),
      .dat_word(dat_word), .dat_last(dat_last),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_word(out_word)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;
   bit stall_mode = 0;
   logic [19:0] got[$];

   function automatic logic [1:0] mpar(input logic [15:0] p);
      return {^(p & 16'hAAAA), ~(^(p & 16'h5555))};
   endfunction

   function automatic logic [4:0] mcrc(input logic [4:0] c_in, input logic [15:0] p);
      logic [4:0] c;
      logic fb;
      c = c_in;
      for (int i = 15; i >= 0; i--) begin
         fb = c[4] ^ p[i];
         c  = {c[3:0], 1'b0};
         if (fb) c = c ^ 5'h05;
      end
      return c;
   endfunction

   task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // output side: random ready, per-cycle flow checks (R8, R10)
   initial begin
      bit          prev_stall;
      logic [19:0] prev_word;
      prev_stall = 0;
      prev_word  = '0;
      out_ready  = 1'b0;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         out_ready = stall_mode ? 1'b0 : ($urandom % 4 != 0);
         #1;
         if (out_valid) chk("R10 busy", {19'd0, cmd_ready}, 20'd0);
         if (prev_stall) chk("R8 hold", {out_valid, out_word[18:0]}, {1'b1, prev_word[18:0]});
         if (!out_ready) chk("R8 in stall", {19'd0, dat_ready}, 20'd0);
         prev_stall = out_valid && !out_ready;
         prev_word  = out_word;
         if (out_valid && out_ready) got.push_back(out_word);
      end
   end

   task automatic run_msg(input logic [7:0] code, input logic [6:0] addr,
                          input logic [15:0] d[$]);
      logic [19:0] exp[$];
      logic [15:0] cp;
      logic [4:0]  c;
      int          n;
      n  = d.size();
      cp = {1'b0, code[6:0], addr, 1'b0};
      c  = mcrc(5'h1F, cp);
      exp.push_back({2'b01, cp, mpar(cp)});
      for (int i = 0; i < n; i++) begin
         exp.push_back({(i == 0) ? 2'b10 : 2'b11, d[i], mpar(d[i])});
         c = mcrc(c, d[i]);
      end
      exp.push_back({2'b01, 4'hC, c, 9'd0});

      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = code; cmd_addr = addr;
      forever begin
         #1;
         if (cmd_ready) begin @(negedge clk); break; end
         @(negedge clk);
      end
      cmd_valid = 1'b0;
      for (int i = 0; i < n; i++) begin
         repeat ($urandom % 3) @(negedge clk);
         dat_valid = 1'b1; dat_word = d[i]; dat_last = (i == n - 1);
         forever begin
            #1;
            if (dat_ready) begin @(negedge clk); break; end
            @(negedge clk);
         end
         dat_valid = 1'b0;
      end
      while (got.size() < exp.size()) @(negedge clk);

      for (int i = 0; i < exp.size(); i++) begin
         string tag;
         if (i == 0)                   tag = "R2 R5 R7 cmd";
         else if (i == exp.size() - 1) tag = (n == 1) ? "R6 R7 R9 crc" : "R6 R7 crc";
         else if (i == 1)              tag = "R3 R5 first";
         else                          tag = "R4 R5 next";
         chk(tag, got[i], exp[i]);
      end
      got.delete();
      @(negedge clk);
      #1;
      chk("R6 idle", {18'd0, cmd_ready, out_valid}, {18'd0, 1'b1, 1'b0});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] q[$];
      void'($urandom(32'd1234));
      rst_n = 1'b0;
      cmd_valid = 0; cmd_code = 0; cmd_addr = 0;
      dat_valid = 0; dat_word = 0; dat_last = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1
      chk("R1 reset", {17'd0, cmd_ready, out_valid, dat_ready}, {17'd0, 3'b100});

      // R9 single payload, R2 code bit 7 masked
      q = '{16'h1234};
      run_msg(8'hFF, 7'h7F, q);
      // R5 extreme payloads
      q = '{16'h0000, 16'hFFFF, 16'hAAAA, 16'h5555};
      run_msg(8'h00, 7'h00, q);
      // R8 forced stall mid-message
      q = '{16'hBEEF, 16'hCAFE, 16'h0F0F, 16'hF0F0, 16'h8001};
      fork
         run_msg(8'h25, 7'h3A, q);
         begin
            repeat (4) @(negedge clk);
            stall_mode = 1;
            repeat (6) @(negedge clk);
            stall_mode = 0;
         end
      join
      // random messages
      for (int m = 0; m < 40; m++) begin
         int len;
         len = 1 + ($urandom % 8);
         q.delete();
         for (int k = 0; k < len; k++) q.push_back(16'($urandom));
         run_msg(8'($urandom), 7'($urandom), q);
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule